// File: doc/BRIEF.md
# Offset-Word Comparator Dividers

This block sits in front of the phase/frequency comparator of a clock synthesizer. It holds the two integer dividers that feed the comparator. The reference path runs on the input clock. It can first halve that clock, then divide by a 7-bit word plus two. The feedback path runs on the oscillator clock and divides by a 9-bit word plus eight. Each path emits a single-cycle event on its own clock once per divided period. The comparator consumes only these events.

A divider word is sampled only when its counter wraps, so a word can be rewritten at any time without producing a truncated period. The halving stage is selected by `cmos_mode`; the single-ended output mode of the surrounding synthesizer needs the halving. A static flag reports when the chosen reference configuration would push the comparison rate below 200 kHz, for the reference frequency given as a parameter. All pins are plain level or pulse signals. There is no data stream and therefore no valid/ready handshake and no back-pressure.

Top module: `pfd_divider_pair`

## Requirements
- R1: With `cmos_mode`=0, `ref_pulse` is high for exactly one `ref_clk` cycle out of every `ref_word`+2 cycles.
- R2: `fb_pulse` is high for exactly one `vco_clk` cycle out of every `fb_word`+8 cycles.
- R3: With `cmos_mode`=1, the reference counter advances only on every second `ref_clk` edge, so `ref_pulse` recurs every 2×(`ref_word`+2) cycles.
- R4: Each pulse lasts exactly one cycle of its own clock and is never high in two consecutive cycles.
- R5: A word is loaded only at the counter wrap, that is, on the edge that raises the pulse. A word presented in the wrap cycle sets the length of the following period, and a change at any other time leaves the running period untouched.
- R6: While `rst_n`=0, both pulses are 0. After release, the first pulse of each path rises on its N-th counting edge, where N is the full divided period. For the reference path in halving mode, the first counting edge is the second rising edge.
- R7: `ref_rate_low`=1 exactly when REF_CLK_KHZ < 200 × P × (`ref_word`+2), with P=2 when `cmos_mode`=1 and P=1 otherwise. Equality gives 0.
- R8: The word extremes hold. Word 0 gives ratios 2 and 8. The all-ones words, 127 and 511, which are the values undriven selects take, give ratios 129 and 519.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference input clock |
| vco_clk | input | 1 | Oscillator clock for the feedback path |
| rst_n | input | 1 | Asynchronous active-low reset for both paths |
| ref_word | input | REF_WORD_W | Reference divider word, ratio = word + 2 |
| fb_word | input | FB_WORD_W | Feedback divider word, ratio = word + 8 |
| cmos_mode | input | 1 | 1 selects the divide-by-2 pre-stage on the reference path |
| ref_pulse | output | 1 | One-cycle reference comparison event (ref_clk domain) |
| fb_pulse | output | 1 | One-cycle feedback comparison event (vco_clk domain) |
| ref_rate_low | output | 1 | Reference comparison rate under the 200 kHz floor |

## Verification
The two functions that can land in the same cycle are the wrap reload and a word change. The bench waits until its reference model is one counting edge away from a wrap, then drives a new word on that falling edge. The expected behaviour is that the new word governs the next period at once and the pulse still fires on time. Words are also changed in the middle of a period, and reset is pulsed while both counters are mid-count. In each case the model, stepped on every edge, decides whether each pulse must be present, and this is compared on every cycle of both clocks.

// File: rtl/pfd_div_pkg.sv
package pfd_div_pkg;
  localparam int unsigned REF_OFFSET     = 2;
  localparam int unsigned FB_OFFSET      = 8;
  localparam int unsigned PREDIV_FACTOR  = 2;
  localparam int unsigned RATE_FLOOR_KHZ = 200;
endpackage

// File: rtl/pfd_prescale.sv
// Count-enable generator: every edge, or every second edge when halving.
module pfd_prescale (
  input  logic clk,
  input  logic rst_n,
  input  logic halve_i,
  output logic en_o
);
  logic phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b0;
    else        phase_q <= ~phase_q;
  end

  assign en_o = !halve_i || phase_q;

  // R3: in halving mode two enabled edges never follow each other
  a_r3_alternate_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (halve_i && $past(halve_i) && en_o) |=> (!en_o || !halve_i));
endmodule

// File: rtl/pfd_wrap_counter.sv
// Down-counter divider: ratio = word + OFFSET, word sampled only at wrap.
module pfd_wrap_counter #(
  parameter int WORD_W = 7,
  parameter int OFFSET = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              pulse_o
);
  localparam int CW = $clog2((1 << WORD_W) + OFFSET);

  logic [CW-1:0] cnt_q;
  logic          fresh_q;
  logic          pulse_q;
  logic [CW-1:0] word_ext;
  logic [CW-1:0] first_load;
  logic [CW-1:0] reload;
  logic          wrap;

  assign word_ext   = CW'(word_i);
  assign first_load = word_ext + CW'(OFFSET - 2);
  assign reload     = word_ext + CW'(OFFSET - 1);
  assign wrap       = en_i && !fresh_q && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      fresh_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= wrap;
      if (en_i) begin
        if (fresh_q) begin
          cnt_q   <= first_load;
          fresh_q <= 1'b0;
        end else if (cnt_q == '0) begin
          cnt_q <= reload;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign pulse_o = pulse_q;

  // Gap tracker: enabled edges since the last pulse began.
  logic [CW:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gap_q <= '0;
    else if (en_i) gap_q <= pulse_q ? (CW+1)'(1) : gap_q + 1'b1;
  end

  // R4: a pulse never lasts two cycles
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);
  // R1: no period shorter than the fixed offset
  a_r1_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> (gap_q >= (CW+1)'(OFFSET)));
  // R5: the reload taken with a pulse comes from the word of that wrap edge
  a_r5_reload_word: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (cnt_q == CW'($past(word_i)) + CW'(OFFSET - 1)));
  // R6: no pulse before the first load after reset
  a_r6_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
    fresh_q |-> !pulse_q);
endmodule

// File: rtl/pfd_rate_check.sv
// Static check of the reference comparison rate against the floor.
module pfd_rate_check import pfd_div_pkg::*; #(
  parameter int          WORD_W  = 7,
  parameter int unsigned CLK_KHZ = 25000
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              halve_i,
  output logic              low_o
);
  logic [31:0] need_khz;

  always_comb begin
    need_khz = RATE_FLOOR_KHZ * (32'(word_i) + REF_OFFSET);
    if (halve_i) need_khz = need_khz * PREDIV_FACTOR;
    low_o = CLK_KHZ < need_khz;
  end
endmodule

// File: rtl/pfd_divider_pair.sv
module pfd_divider_pair import pfd_div_pkg::*; #(
  parameter int          REF_WORD_W  = 7,
  parameter int          FB_WORD_W   = 9,
  parameter int unsigned REF_CLK_KHZ = 25000
) (
  input  logic                  ref_clk,
  input  logic                  vco_clk,
  input  logic                  rst_n,
  input  logic [REF_WORD_W-1:0] ref_word,
  input  logic [FB_WORD_W-1:0]  fb_word,
  input  logic                  cmos_mode,
  output logic                  ref_pulse,
  output logic                  fb_pulse,
  output logic                  ref_rate_low
);
  logic ref_en;

  pfd_prescale u_prescale (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .halve_i (cmos_mode),
    .en_o    (ref_en)
  );

  pfd_wrap_counter #(.WORD_W(REF_WORD_W), .OFFSET(int'(REF_OFFSET))) u_ref_div (
    .clk     (ref_clk),
    .rst_n   (rst_n),
    .en_i    (ref_en),
    .word_i  (ref_word),
    .pulse_o (ref_pulse)
  );

  pfd_wrap_counter #(.WORD_W(FB_WORD_W), .OFFSET(int'(FB_OFFSET))) u_fb_div (
    .clk     (vco_clk),
    .rst_n   (rst_n),
    .en_i    (1'b1),
    .word_i  (fb_word),
    .pulse_o (fb_pulse)
  );

  pfd_rate_check #(.WORD_W(REF_WORD_W), .CLK_KHZ(REF_CLK_KHZ)) u_rate (
    .word_i  (ref_word),
    .halve_i (cmos_mode),
    .low_o   (ref_rate_low)
  );
endmodule

// File: tb/pfd_divider_pair_tb_top.sv
`timescale 1ns/10ps
module pfd_divider_pair_tb_top;
  localparam int unsigned KHZ = 25000;

  logic       ref_clk = 1'b0;
  logic       vco_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmos_mode = 1'b0;
  logic [6:0] ref_word = '1;
  logic [8:0] fb_word = '1;
  logic       ref_pulse, fb_pulse, ref_rate_low;

  always #4   ref_clk = ~ref_clk;   // 125 MHz
  always #2.5 vco_clk = ~vco_clk;

  pfd_divider_pair #(.REF_WORD_W(7), .FB_WORD_W(9), .REF_CLK_KHZ(KHZ)) dut_i (
    .ref_clk(ref_clk), .vco_clk(vco_clk), .rst_n(rst_n),
    .ref_word(ref_word), .fb_word(fb_word), .cmos_mode(cmos_mode),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .ref_rate_low(ref_rate_low)
  );

  int    checks_n = 0;
  int    fails_n = 0;
  string ref_tag = "R6";
  string fb_tag = "R6";
  bit    done = 0;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks_n++;
    if (act != exp) begin
      fails_n++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks_n, fails_n);
    $finish;
  endtask

  // Behavioural reference model, reference path
  int m_rphase, m_rcnt, m_rratio;
  bit m_rstart, m_rexp;
  always @(posedge ref_clk or negedge rst_n) begin : ref_model
    bit en;
    if (!rst_n) begin
      m_rphase = 0; m_rcnt = 0; m_rratio = 0; m_rstart = 0; m_rexp = 0;
    end else begin
      en = !cmos_mode || (m_rphase == 1);
      m_rphase = 1 - m_rphase;
      m_rexp = 0;
      if (en) begin
        if (!m_rstart) begin
          m_rstart = 1; m_rratio = int'(ref_word) + 2; m_rcnt = 1;
        end else m_rcnt++;
        if (m_rcnt == m_rratio) begin
          m_rexp = 1; m_rcnt = 0; m_rratio = int'(ref_word) + 2;
        end
      end
    end
  end

  // Behavioural reference model, feedback path
  int m_fcnt, m_fratio;
  bit m_fstart, m_fexp;
  always @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      m_fcnt = 0; m_fratio = 0; m_fstart = 0; m_fexp = 0;
    end else begin
      m_fexp = 0;
      if (!m_fstart) begin
        m_fstart = 1; m_fratio = int'(fb_word) + 8; m_fcnt = 1;
      end else m_fcnt++;
      if (m_fcnt == m_fratio) begin
        m_fexp = 1; m_fcnt = 0; m_fratio = int'(fb_word) + 8;
      end
    end
  end

  // Per-cycle comparison, sampled on the falling edge
  logic ref_prev = 1'b0;
  logic fb_prev = 1'b0;
  always @(negedge ref_clk) begin
    if (!done) begin
      check(ref_tag, "ref_pulse", ref_pulse, m_rexp);
      if (ref_prev) check("R4", "ref_pulse second cycle", ref_pulse, 0);
      ref_prev = ref_pulse;
    end
  end
  always @(negedge vco_clk) begin
    if (!done) begin
      check(fb_tag, "fb_pulse", fb_pulse, m_fexp);
      if (fb_prev) check("R4", "fb_pulse second cycle", fb_pulse, 0);
      fb_prev = fb_pulse;
    end
  end

  // Watchdog
  int cyc = 0;
  always @(posedge ref_clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails_n++;
      $display("FAIL R6 watchdog: actual %0d cycles expected completion", cyc);
      done = 1;
      finish_up();
    end
  end

  task automatic run_ref(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic check_rate();
    int p;
    int need;
    #1;
    p = cmos_mode ? 2 : 1;
    need = 200 * p * (int'(ref_word) + 2);
    check("R7", "ref_rate_low", ref_rate_low, (int'(KHZ) < need) ? 1 : 0);
  endtask

  task automatic set_ref(input int w);
    @(negedge ref_clk);
    ref_word = 7'(w);
  endtask

  task automatic set_fb(input int w);
    @(negedge vco_clk);
    fb_word = 9'(w);
  endtask

  task automatic do_reset(input bit mode);
    @(negedge ref_clk);
    #0.3 rst_n = 1'b0;
    cmos_mode = mode;
    ref_tag = "R6"; fb_tag = "R6";
    repeat (3) @(negedge ref_clk);
    check("R6", "ref_pulse held in reset", ref_pulse, 0);
    check("R6", "fb_pulse held in reset", fb_pulse, 0);
    #0.3 rst_n = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge ref_clk);
    check("R6", "ref_pulse in reset", ref_pulse, 0);
    check("R6", "fb_pulse in reset", fb_pulse, 0);
    check_rate();                       // R7: 127, no halving -> 25800 > 25000
    @(negedge ref_clk);
    #0.3 rst_n = 1'b1;

    // R8: default all-ones words, 129 and 519
    ref_tag = "R8"; fb_tag = "R8";
    run_ref(1100);

    // R8: zero words, 2 and 8
    set_ref(0); set_fb(0);
    run_ref(200);
    check_rate();

    // R1 / R2: 59 and 276 give 61 and 284
    ref_tag = "R1"; fb_tag = "R2";
    set_ref(59); set_fb(276);
    run_ref(800);
    check_rate();
    set_ref(123); check_rate();         // R7 boundary: equal -> 0
    set_ref(124); check_rate();         // R7 just above -> 1
    set_ref(59);
    run_ref(100);

    // R5: change presented in the wrap cycle
    ref_tag = "R5"; fb_tag = "R5";
    do @(negedge ref_clk); while (!(m_rstart && m_rcnt == m_rratio - 1));
    ref_word = 7'd5;
    run_ref(100);
    do @(negedge vco_clk); while (!(m_fstart && m_fcnt == m_fratio - 1));
    fb_word = 9'd20;
    run_ref(150);
    // R5: change in the middle of a period
    set_ref(40); set_fb(100);
    run_ref(40);
    set_ref(9); set_fb(3);
    run_ref(300);

    // R6: reset while both counters are mid-count
    set_ref(17); set_fb(33);
    run_ref(7);
    do_reset(1'b0);
    ref_tag = "R6"; fb_tag = "R6";
    run_ref(120);

    // R3: halving mode
    set_ref(3);
    do_reset(1'b1);
    ref_tag = "R3"; fb_tag = "R2";
    run_ref(200);
    set_ref(0);
    run_ref(60);
    check_rate();
    set_ref(60); check_rate();          // R7 halving: 24800 -> 0
    set_ref(61); check_rate();          // R7 halving: 25200 -> 1
    run_ref(400);
    do @(negedge ref_clk); while (!(m_rstart && m_rcnt == m_rratio - 1));
    ref_word = 7'd2;                    // R5 in halving mode
    ref_tag = "R5";
    run_ref(200);

    done = 1;
    finish_up();
  end
endmodule